// File: doc/BRIEF.md
# Register Stack Frame Controller

This block keeps track of the register window that a procedure sees in a stacked general-register file. It holds a current frame marker and a saved previous marker. Each marker has a total frame size and a local-area size, and the output area is the difference between them. It also holds a base pointer into a circular physical file of stacked registers, and it translates logical register numbers into physical slots from that pointer. Registers below the first stacked number are static and pass through without renaming.

Four operations change the window. A call starts the callee's frame exactly at the caller's output area. A return restores the saved marker and moves the base back by the caller's local size. An allocation resizes the current frame in place. A cover pushes an empty frame just above the whole current frame. A dirty counter counts the physical registers held by frames below the current one. When an operation would need more registers than the file has, the block reports how many must be spilled. When a return needs registers that are no longer in the file, it reports how many must be filled. Moving data to and from memory is left to a separate engine.

Operations arrive on a valid/ready channel. `op_ready` is low during reset and high at all other times, so the block never applies back-pressure. An operation is accepted on any rising edge where both `op_valid` and `op_ready` are high. While `op_valid` is low, the opcode and size inputs may change freely. Translation is combinational and depends only on the registered state and `lreg`.

Top module: `rsf_ctrl`

## Requirements
- R1: After reset the current and previous markers are 0/0, the base is 0, the dirty count is 0, no event is raised, and `op_ready` is low during reset and high afterwards.
- R2: A logical number below 32 gives `phys_stacked`=0, `phys_idx` equal to `lreg`, and `reg_illegal`=0.
- R3: A logical number n of 32 or more gives `phys_stacked`=1 and `phys_idx`=(base+n-32) mod 96. `reg_illegal` is 1 exactly when n >= 32+sof.
- R4: A call (opcode 2'b00) sets sof to the old sof-sol and sol to 0. It copies the old current marker into the previous marker, advances the base by the old sol, and adds the old sol to the dirty count.
- R5: A return (opcode 2'b01) copies the previous marker into the current one, moves the base back by the previous sol, and subtracts that sol from the dirty count. If the dirty count is smaller than that sol, `evt_unf` pulses, `xfer_cnt` gives the shortfall, and the dirty count becomes 0.
- R6: An allocation (opcode 2'b10) with sol <= sof <= 96 loads `alloc_sof` and `alloc_sol` into the current marker. It leaves the base and the previous marker unchanged.
- R7: An allocation with sol > sof or sof > 96 pulses `evt_err` and changes no state.
- R8: If an allocation or a return would make dirty+sof exceed 96, the new frame is still applied. In that case `evt_ovf` pulses, `xfer_cnt` gives the excess, and the dirty count becomes 96 minus the new sof. A total of exactly 96 raises no event.
- R9: A cover (opcode 2'b11) advances the base by the old sof and adds the old sof to the dirty count. It copies the old marker into the previous marker and sets the current marker to 0/0.
- R10: The event flags are one-cycle pulses in the cycle after the operation, and at most one is high at a time. `xfer_cnt` is 0 when no event is raised. Nothing changes while `op_valid` is low.
- R11: Every move of the base wraps modulo 96 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Operation can be taken |
| op_code | input | 2 | 00 call, 01 return, 10 allocate, 11 cover |
| alloc_sof | input | 7 | Requested total size for allocate |
| alloc_sol | input | 7 | Requested local size for allocate |
| lreg | input | 7 | Logical register number to translate |
| phys_idx | output | 7 | Physical slot (or static number) |
| phys_stacked | output | 1 | lreg is a stacked register |
| reg_illegal | output | 1 | lreg lies beyond the current frame |
| cur_sof | output | 7 | Current frame total size |
| cur_sol | output | 7 | Current frame local size |
| prv_sof | output | 7 | Previous frame total size |
| prv_sol | output | 7 | Previous frame local size |
| dirty_cnt | output | 7 | Registers held by frames below the current one |
| evt_ovf | output | 1 | Spill needed, pulse |
| evt_unf | output | 1 | Fill needed, pulse |
| evt_err | output | 1 | Allocation rejected, pulse |
| xfer_cnt | output | 7 | Registers to spill or fill for the pulsed event |

## Verification
The bench follows a call, grow, return sequence in which a callee's register 32 must land on the caller's first output slot. A design that placed the new base at the caller's sof instead of its sol would translate to the wrong slot, and the bench would see it.

Several corner cases get their own checks:
- Returns that walk the base below slot 0 check the backward wrap. A missing wrap would give an out-of-range index.
- Successive returns run the dirty count short, and the shortfall must appear in `xfer_cnt`. Unsigned arithmetic that wraps would give a huge dirty count instead.
- Allocations totalling exactly 96 and one past 96 test the boundary of the spill request. An off-by-one comparison would flag the wrong one.
- Rejected allocations must leave every field unchanged.
- The first illegal register sits just past the frame edge, and a comparison that is off by one would either reject the last legal register or accept the first illegal one.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

  typedef enum logic [1:0] {
    OP_CALL  = 2'b00,
    OP_RET   = 2'b01,
    OP_ALLOC = 2'b10,
    OP_COVER = 2'b11
  } rsf_op_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic err;
  } rsf_evt_t;

endpackage

// File: rtl/rsf_xlate.sv
module rsf_xlate #(
  parameter int NPHYS       = 96,
  parameter int LREG_W      = 7,
  parameter int STATIC_REGS = 32,
  parameter int CW          = 7
) (
  input  logic [CW-1:0]     base,
  input  logic [CW-1:0]     sof,
  input  logic [LREG_W-1:0] lreg,
  output logic [CW-1:0]     idx,
  output logic              stacked,
  output logic              illegal
);
  localparam int SW = ((LREG_W > CW) ? LREG_W : CW) + 2;
  localparam logic [SW-1:0] STAT = SW'(STATIC_REGS);
  localparam logic [SW-1:0] NP   = SW'(NPHYS);

  logic [SW-1:0] lr_w, off, sum, wrapped;

  assign lr_w    = SW'(lreg);
  assign stacked = (lr_w >= STAT);
  assign off     = stacked ? (lr_w - STAT) : '0;
  assign sum     = SW'(base) + off;

  // A power-of-two file wraps by masking; any other size wraps by one compare-subtract.
  generate
    if ((NPHYS & (NPHYS - 1)) == 0) begin : g_pow2
      assign wrapped = sum & (NP - SW'(1));
    end else begin : g_cmp
      assign wrapped = (sum >= NP) ? (sum - NP) : sum;
    end
  endgenerate

  assign idx     = stacked ? wrapped[CW-1:0] : lr_w[CW-1:0];
  assign illegal = stacked && (off >= SW'(sof));
endmodule

// File: rtl/rsf_next.sv
module rsf_next
  import rsf_pkg::*;
#(
  parameter int NPHYS = 96,
  parameter int CW    = 7
) (
  input  logic          fire,
  input  rsf_op_e       op,
  input  logic [CW-1:0] a_sof,
  input  logic [CW-1:0] a_sol,
  input  logic [CW-1:0] c_sof,
  input  logic [CW-1:0] c_sol,
  input  logic [CW-1:0] p_sof,
  input  logic [CW-1:0] p_sol,
  input  logic [CW-1:0] base,
  input  logic [CW-1:0] dirty,
  output logic [CW-1:0] n_c_sof,
  output logic [CW-1:0] n_c_sol,
  output logic [CW-1:0] n_p_sof,
  output logic [CW-1:0] n_p_sol,
  output logic [CW-1:0] n_base,
  output logic [CW-1:0] n_dirty,
  output rsf_evt_t      n_evt,
  output logic [CW-1:0] n_xfer
);
  localparam int SW = CW + 2;
  localparam logic [SW-1:0] NP = SW'(NPHYS);

  function automatic logic [CW-1:0] mod_add(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [SW-1:0] s;
    s = SW'(a) + SW'(b);
    if (s >= NP) s = s - NP;
    return s[CW-1:0];
  endfunction

  function automatic logic [CW-1:0] mod_sub(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [SW-1:0] s;
    if (a >= b) s = SW'(a) - SW'(b);
    else        s = SW'(a) + NP - SW'(b);
    return s[CW-1:0];
  endfunction

  logic [SW-1:0] total;
  logic [CW-1:0] d_ret;

  always_comb begin
    n_c_sof = c_sof;
    n_c_sol = c_sol;
    n_p_sof = p_sof;
    n_p_sol = p_sol;
    n_base  = base;
    n_dirty = dirty;
    n_evt   = '0;
    n_xfer  = '0;
    total   = '0;
    d_ret   = '0;
    if (fire) begin
      unique case (op)
        OP_CALL: begin
          n_base  = mod_add(base, c_sol);
          n_dirty = dirty + c_sol;
          n_p_sof = c_sof;
          n_p_sol = c_sol;
          n_c_sof = c_sof - c_sol;
          n_c_sol = '0;
        end
        OP_RET: begin
          n_c_sof = p_sof;
          n_c_sol = p_sol;
          n_base  = mod_sub(base, p_sol);
          if (dirty >= p_sol) begin
            d_ret = dirty - p_sol;
          end else begin
            d_ret     = '0;
            n_evt.unf = 1'b1;
            n_xfer    = p_sol - dirty;
          end
          total = SW'(d_ret) + SW'(p_sof);
          if (total > NP) begin
            n_evt.ovf = 1'b1;
            n_xfer    = CW'(total - NP);
            n_dirty   = CW'(NP - SW'(p_sof));
          end else begin
            n_dirty = d_ret;
          end
        end
        OP_ALLOC: begin
          if ((a_sol > a_sof) || (SW'(a_sof) > NP)) begin
            n_evt.err = 1'b1;
          end else begin
            n_c_sof = a_sof;
            n_c_sol = a_sol;
            total   = SW'(dirty) + SW'(a_sof);
            if (total > NP) begin
              n_evt.ovf = 1'b1;
              n_xfer    = CW'(total - NP);
              n_dirty   = CW'(NP - SW'(a_sof));
            end
          end
        end
        OP_COVER: begin
          n_base  = mod_add(base, c_sof);
          n_dirty = dirty + c_sof;
          n_p_sof = c_sof;
          n_p_sol = c_sol;
          n_c_sof = '0;
          n_c_sol = '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rsf_ctrl.sv
module rsf_ctrl
  import rsf_pkg::*;
#(
  parameter int NPHYS       = 96,
  parameter int LREG_W      = 7,
  parameter int STATIC_REGS = 32,
  localparam int CW         = $clog2(NPHYS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_code,
  input  logic [CW-1:0]     alloc_sof,
  input  logic [CW-1:0]     alloc_sol,
  input  logic [LREG_W-1:0] lreg,
  output logic [CW-1:0]     phys_idx,
  output logic              phys_stacked,
  output logic              reg_illegal,
  output logic [CW-1:0]     cur_sof,
  output logic [CW-1:0]     cur_sol,
  output logic [CW-1:0]     prv_sof,
  output logic [CW-1:0]     prv_sol,
  output logic [CW-1:0]     dirty_cnt,
  output logic              evt_ovf,
  output logic              evt_unf,
  output logic              evt_err,
  output logic [CW-1:0]     xfer_cnt
);
  logic          ready_q, fire;
  logic [CW-1:0] base_q;
  logic [CW-1:0] n_c_sof, n_c_sol, n_p_sof, n_p_sol, n_base, n_dirty, n_xfer;
  rsf_evt_t      evt_q, n_evt;

  assign fire     = op_valid && ready_q;
  assign op_ready = ready_q;

  rsf_next #(.NPHYS(NPHYS), .CW(CW)) u_next (
    .fire    (fire),
    .op      (rsf_op_e'(op_code)),
    .a_sof   (alloc_sof),
    .a_sol   (alloc_sol),
    .c_sof   (cur_sof),
    .c_sol   (cur_sol),
    .p_sof   (prv_sof),
    .p_sol   (prv_sol),
    .base    (base_q),
    .dirty   (dirty_cnt),
    .n_c_sof (n_c_sof),
    .n_c_sol (n_c_sol),
    .n_p_sof (n_p_sof),
    .n_p_sol (n_p_sol),
    .n_base  (n_base),
    .n_dirty (n_dirty),
    .n_evt   (n_evt),
    .n_xfer  (n_xfer)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q   <= 1'b0;
      cur_sof   <= '0;
      cur_sol   <= '0;
      prv_sof   <= '0;
      prv_sol   <= '0;
      base_q    <= '0;
      dirty_cnt <= '0;
      evt_q     <= '0;
      xfer_cnt  <= '0;
    end else begin
      ready_q   <= 1'b1;
      cur_sof   <= n_c_sof;
      cur_sol   <= n_c_sol;
      prv_sof   <= n_p_sof;
      prv_sol   <= n_p_sol;
      base_q    <= n_base;
      dirty_cnt <= n_dirty;
      evt_q     <= n_evt;
      xfer_cnt  <= n_xfer;
    end
  end

  assign evt_ovf = evt_q.ovf;
  assign evt_unf = evt_q.unf;
  assign evt_err = evt_q.err;

  rsf_xlate #(
    .NPHYS(NPHYS), .LREG_W(LREG_W), .STATIC_REGS(STATIC_REGS), .CW(CW)
  ) u_xlate (
    .base    (base_q),
    .sof     (cur_sof),
    .lreg    (lreg),
    .idx     (phys_idx),
    .stacked (phys_stacked),
    .illegal (reg_illegal)
  );
endmodule

// File: rtl/rsf_ctrl_chk.sv
module rsf_ctrl_chk #(
  parameter int NPHYS       = 96,
  parameter int LREG_W      = 7,
  parameter int STATIC_REGS = 32,
  parameter int CW          = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic              op_ready,
  input logic [1:0]        op_code,
  input logic [CW-1:0]     alloc_sof,
  input logic [CW-1:0]     alloc_sol,
  input logic [LREG_W-1:0] lreg,
  input logic [CW-1:0]     phys_idx,
  input logic              phys_stacked,
  input logic              reg_illegal,
  input logic [CW-1:0]     cur_sof,
  input logic [CW-1:0]     cur_sol,
  input logic [CW-1:0]     prv_sof,
  input logic [CW-1:0]     prv_sol,
  input logic [CW-1:0]     dirty_cnt,
  input logic              evt_ovf,
  input logic              evt_unf,
  input logic              evt_err
);
  logic fire;
  assign fire = op_valid && op_ready;

  p_static_r2: assert property (@(posedge clk) disable iff (rst)
    (int'(lreg) < STATIC_REGS) |-> (!phys_stacked && !reg_illegal && int'(phys_idx) == int'(lreg)));

  p_illegal_r3: assert property (@(posedge clk) disable iff (rst)
    (int'(lreg) >= STATIC_REGS + int'(cur_sof)) |-> reg_illegal);

  p_index_range_r11: assert property (@(posedge clk) disable iff (rst)
    phys_stacked |-> (int'(phys_idx) < NPHYS));

  p_call_frame_r4: assert property (@(posedge clk) disable iff (rst)
    (fire && op_code == 2'b00) |=>
      (cur_sol == '0 && int'(cur_sof) == int'($past(cur_sof)) - int'($past(cur_sol))
       && prv_sof == $past(cur_sof) && prv_sol == $past(cur_sol)));

  p_local_fits_r6: assert property (@(posedge clk) disable iff (rst)
    cur_sol <= cur_sof);

  p_reject_r7: assert property (@(posedge clk) disable iff (rst)
    (fire && op_code == 2'b10 && alloc_sol > alloc_sof) |=>
      (evt_err && $stable(cur_sof) && $stable(cur_sol) && $stable(dirty_cnt)));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (int'(dirty_cnt) + int'(cur_sof)) <= NPHYS);

  p_cover_r9: assert property (@(posedge clk) disable iff (rst)
    (fire && op_code == 2'b11) |=>
      (cur_sof == '0 && cur_sol == '0 && prv_sof == $past(cur_sof)
       && int'(dirty_cnt) == int'($past(dirty_cnt)) + int'($past(cur_sof))));

  p_one_event_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_ovf, evt_unf, evt_err}));

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!evt_ovf && !evt_unf && !evt_err && $stable(cur_sof)
                   && $stable(cur_sol) && $stable(dirty_cnt)));
endmodule

bind rsf_ctrl rsf_ctrl_chk #(
  .NPHYS(NPHYS), .LREG_W(LREG_W), .STATIC_REGS(STATIC_REGS), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code),
  .alloc_sof(alloc_sof), .alloc_sol(alloc_sol), .lreg(lreg), .phys_idx(phys_idx),
  .phys_stacked(phys_stacked), .reg_illegal(reg_illegal), .cur_sof(cur_sof),
  .cur_sol(cur_sol), .prv_sof(prv_sof), .prv_sol(prv_sol), .dirty_cnt(dirty_cnt),
  .evt_ovf(evt_ovf), .evt_unf(evt_unf), .evt_err(evt_err)
);

// File: tb/rsf_ctrl_test.sv
module rsf_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [1:0] op_code = 2'b00;
  logic [6:0] alloc_sof = '0, alloc_sol = '0, lreg = 7'd32;
  logic       op_ready, phys_stacked, reg_illegal, evt_ovf, evt_unf, evt_err;
  logic [6:0] phys_idx, cur_sof, cur_sol, prv_sof, prv_sol, dirty_cnt, xfer_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  rsf_ctrl uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code),
    .alloc_sof(alloc_sof), .alloc_sol(alloc_sol), .lreg(lreg), .phys_idx(phys_idx),
    .phys_stacked(phys_stacked), .reg_illegal(reg_illegal), .cur_sof(cur_sof),
    .cur_sol(cur_sol), .prv_sof(prv_sof), .prv_sol(prv_sol), .dirty_cnt(dirty_cnt),
    .evt_ovf(evt_ovf), .evt_unf(evt_unf), .evt_err(evt_err), .xfer_cnt(xfer_cnt)
  );

  // op, alloc sof/sol, expected sof, sol, prev sof, prev sol, base, dirty, xfer, {ovf,unf,err}
  typedef struct packed {
    logic [1:0] op;
    logic [6:0] a_sof, a_sol, e_sof, e_sol, e_psof, e_psol, e_base, e_dirty, e_xfer;
    logic [2:0] e_evt;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{2'b10, 7'd21, 7'd14, 7'd21, 7'd14, 7'd0,  7'd0,  7'd0,  7'd0,  7'd0,  3'b000},
    '{2'b00, 7'd0,  7'd0,  7'd7,  7'd0,  7'd21, 7'd14, 7'd14, 7'd14, 7'd0,  3'b000},
    '{2'b10, 7'd19, 7'd16, 7'd19, 7'd16, 7'd21, 7'd14, 7'd14, 7'd14, 7'd0,  3'b000},
    '{2'b01, 7'd0,  7'd0,  7'd21, 7'd14, 7'd21, 7'd14, 7'd0,  7'd0,  7'd0,  3'b000},
    '{2'b00, 7'd0,  7'd0,  7'd7,  7'd0,  7'd21, 7'd14, 7'd14, 7'd14, 7'd0,  3'b000},
    '{2'b11, 7'd0,  7'd0,  7'd0,  7'd0,  7'd7,  7'd0,  7'd21, 7'd21, 7'd0,  3'b000},
    '{2'b10, 7'd5,  7'd0,  7'd5,  7'd0,  7'd7,  7'd0,  7'd21, 7'd21, 7'd0,  3'b000},
    '{2'b10, 7'd3,  7'd5,  7'd5,  7'd0,  7'd7,  7'd0,  7'd21, 7'd21, 7'd0,  3'b001},
    '{2'b10, 7'd97, 7'd0,  7'd5,  7'd0,  7'd7,  7'd0,  7'd21, 7'd21, 7'd0,  3'b001},
    '{2'b10, 7'd80, 7'd10, 7'd80, 7'd10, 7'd7,  7'd0,  7'd21, 7'd16, 7'd5,  3'b100},
    '{2'b00, 7'd0,  7'd0,  7'd70, 7'd0,  7'd80, 7'd10, 7'd31, 7'd26, 7'd0,  3'b000},
    '{2'b01, 7'd0,  7'd0,  7'd80, 7'd10, 7'd80, 7'd10, 7'd21, 7'd16, 7'd0,  3'b000},
    '{2'b01, 7'd0,  7'd0,  7'd80, 7'd10, 7'd80, 7'd10, 7'd11, 7'd6,  7'd0,  3'b000},
    '{2'b01, 7'd0,  7'd0,  7'd80, 7'd10, 7'd80, 7'd10, 7'd1,  7'd0,  7'd4,  3'b010},
    '{2'b01, 7'd0,  7'd0,  7'd80, 7'd10, 7'd80, 7'd10, 7'd87, 7'd0,  7'd10, 3'b010},
    '{2'b11, 7'd0,  7'd0,  7'd0,  7'd0,  7'd80, 7'd10, 7'd71, 7'd80, 7'd0,  3'b000},
    '{2'b10, 7'd16, 7'd0,  7'd16, 7'd0,  7'd80, 7'd10, 7'd71, 7'd80, 7'd0,  3'b000},
    '{2'b10, 7'd17, 7'd0,  7'd17, 7'd0,  7'd80, 7'd10, 7'd71, 7'd79, 7'd1,  3'b100},
    '{2'b00, 7'd0,  7'd0,  7'd17, 7'd0,  7'd17, 7'd0,  7'd71, 7'd79, 7'd0,  3'b000},
    '{2'b10, 7'd96, 7'd96, 7'd96, 7'd96, 7'd17, 7'd0,  7'd71, 7'd0,  7'd79, 3'b100},
    '{2'b00, 7'd0,  7'd0,  7'd0,  7'd0,  7'd96, 7'd96, 7'd71, 7'd96, 7'd0,  3'b000}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [6:0] s, input logic [6:0] l);
    @(negedge clk);
    op_valid  = 1'b1;
    op_code   = op;
    alloc_sof = s;
    alloc_sol = l;
    @(negedge clk);
    op_valid  = 1'b0;
  endtask

  function automatic string tag_of(input vec_t v);
    case (v.op)
      2'b00:   return "R4 call";
      2'b01:   return (v.e_evt == 3'b010) ? "R5 return underflow" : "R5 return";
      2'b10:   return (v.e_evt == 3'b001) ? "R7 reject" :
                      (v.e_evt == 3'b100) ? "R8 alloc overflow" : "R6 alloc";
      default: return "R9 cover";
    endcase
  endfunction

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 ready held in reset", int'(op_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", int'(op_ready), 1);
    check("R1 cur sof", int'(cur_sof), 0);
    check("R1 prev sof", int'(prv_sof), 0);
    check("R1 dirty", int'(dirty_cnt), 0);
    check("R1 events", int'({evt_ovf, evt_unf, evt_err}), 0);
    check("R1 base", int'(phys_idx), 0);

    for (int i = 0; i < NV; i++) begin
      do_op(VECS[i].op, VECS[i].a_sof, VECS[i].a_sol);
      check(tag_of(VECS[i]), int'(cur_sof), int'(VECS[i].e_sof));
      check(tag_of(VECS[i]), int'(cur_sol), int'(VECS[i].e_sol));
      check(tag_of(VECS[i]), int'(prv_sof), int'(VECS[i].e_psof));
      check(tag_of(VECS[i]), int'(prv_sol), int'(VECS[i].e_psol));
      check(tag_of(VECS[i]), int'(phys_idx), int'(VECS[i].e_base)); // R11 wrap on return/cover rows
      check(tag_of(VECS[i]), int'(dirty_cnt), int'(VECS[i].e_dirty));
      check(tag_of(VECS[i]), int'(xfer_cnt), int'(VECS[i].e_xfer));
      check(tag_of(VECS[i]), int'({evt_ovf, evt_unf, evt_err}), int'(VECS[i].e_evt));
    end

    // R10: event pulse drops one cycle later
    @(negedge clk);
    check("R10 pulse clears", int'({evt_ovf, evt_unf, evt_err}), 0);

    // R8: base 71, dirty 96, empty frame; grow to 40 spills 40
    do_op(2'b10, 7'd40, 7'd0);
    check("R8 ovf", int'(evt_ovf), 1);
    check("R8 xfer", int'(xfer_cnt), 40);
    check("R8 dirty", int'(dirty_cnt), 56);

    // R3 and R11: translation wraps modulo 96
    lreg = 7'd62;
    #1 check("R11 idx wrap", int'(phys_idx), 5);
    lreg = 7'd71;
    #1 check("R3 last legal", int'(reg_illegal), 0);
    check("R3 last legal idx", int'(phys_idx), 14);
    check("R3 stacked", int'(phys_stacked), 1);
    lreg = 7'd72;
    #1 check("R3 first illegal", int'(reg_illegal), 1);

    // R2: static registers pass through
    lreg = 7'd5;
    #1 check("R2 static idx", int'(phys_idx), 5);
    check("R2 static flag", int'(phys_stacked), 0);
    check("R2 static legal", int'(reg_illegal), 0);
    lreg = 7'd31;
    #1 check("R2 static top", int'(phys_idx), 31);

    // R10: op inputs ignored while op_valid low
    @(negedge clk);
    op_code   = 2'b10;
    alloc_sof = 7'd3;
    alloc_sol = 7'd1;
    repeat (2) @(negedge clk);
    check("R10 idle sof", int'(cur_sof), 40);
    check("R10 idle sol", int'(cur_sol), 0);
    check("R10 idle events", int'({evt_ovf, evt_unf, evt_err}), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule